// File: doc/BRIEF.md
# Lazy token ring node

This block is one station of a ring that shares a single resource by passing one token between stations. A local client asks for the resource with a request line, is answered with a grant, signals the end of its use with a done line, and then drops its request. Towards the ring, the node has a request/acknowledge pair facing its left neighbour (incoming requests for the token) and another pair facing its right neighbour (outgoing requests for the token). Stations are chained so that each node's right-hand request drives the next node's left-hand request input, and that node's left-hand acknowledge returns as the first node's right-hand acknowledge. The token therefore travels from right to left.

The node is lazy. After its client finishes, it keeps the token and does nothing more. The token moves only when a left neighbour asks for it. A node that lacks the token and gets a request from its client or from its left neighbour first fetches the token from its right. If it was fetching for its left neighbour, it then hands the token straight on. A two-input mutual exclusion stage decides between the local client and the left neighbour, and the local client wins a tie. Every handshake is four-phase: request up, acknowledge up, request down, acknowledge down. All inputs are sampled on the clock. A parameter selects whether the node starts out holding the token, and exactly one node of a ring should do so.

Top module: `lazy_ring_node`

## Requirements
- R1: While reset is held and after it is released, `holds_token` equals the `HAS_TOKEN` parameter, and `cli_grant`, `lft_ack` and `rgt_req` are low.
- R2: If the node holds the token and sees `cli_req` high while idle, `cli_grant` goes high on that same clock edge and `rgt_req` stays low.
- R3: If the node lacks the token and sees `cli_req` high while idle, `rgt_req` goes high on that edge. `cli_grant` rises only after `rgt_ack` has been seen high, and by then `holds_token` is 1.
- R4: `cli_grant` stays high while `cli_req` is high, even after `cli_done`. It drops on the first edge where `cli_done` has been seen during the grant and `cli_req` is low. The token stays in the node, so a later local request is granted with no ring traffic.
- R5: If the node holds the token and sees `lft_req` while idle, it raises `lft_ack` and clears `holds_token` on the same edge. `lft_ack` stays high until `lft_req` is seen low, and drops on that edge.
- R6: If the node lacks the token and sees `lft_req` while idle, it first fetches the token through `rgt_req`/`rgt_ack`, then raises `lft_ack`. It ends the exchange without the token.
- R7: If `cli_req` and `lft_req` are both seen in the same idle cycle, the local client is served first. `lft_ack` is not raised until `cli_grant` has been withdrawn.
- R8: `rgt_req` stays high until `rgt_ack` is seen high, and then drops. The node neither grants nor passes the token until `rgt_ack` is seen low again.
- R9: In a ring of chained nodes with one initial holder, at most one node holds the token and at most one `cli_grant` is high in any cycle. The token is never lost.
- R10: At most one of `cli_grant`, `lft_ack` and `rgt_req` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cli_req | input | 1 | Local client asks for the resource |
| cli_done | input | 1 | Local client has finished its use (pulse or level) |
| cli_grant | output | 1 | Resource granted to the local client |
| lft_req | input | 1 | Left neighbour asks for the token |
| lft_ack | output | 1 | Token handed to the left neighbour |
| rgt_req | output | 1 | This node asks its right neighbour for the token |
| rgt_ack | input | 1 | Right neighbour has handed over the token |
| holds_token | output | 1 | The token is currently inside this node |

## Verification
The bench builds a three-node ring and tracks which node must be granted next. The hardest case is a local request and a left-neighbour request that land in the same cycle. A node that served the left side first, or granted both, would show the wrong grant order, two grants at once, or an acknowledge raised during a grant. It also sends a request through a node that lacks the token, so that node has to fetch the token and forward it. A node that kept the token, or acknowledged before fetching, would leave the token in two places or in none. A node that drops the grant on `cli_done` while the request is still high, or that gives the token up after use, shows up in the grant timing and in ring traffic on a repeat request.

// File: rtl/lrn_pkg.sv
package lrn_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_FETCH   = 3'd1,
    ST_GRANTED = 3'd2,
    ST_PASS    = 3'd3,
    ST_RETURN  = 3'd4
  } lrn_state_e;

  typedef enum logic {
    SRV_LOCAL = 1'b0,
    SRV_LEFT  = 1'b1
  } lrn_owner_e;
endpackage

// File: rtl/lrn_mutex.sv
module lrn_mutex #(
  parameter bit LOCAL_FIRST = 1'b1
) (
  input  logic en,
  input  logic loc_req,
  input  logic lft_req,
  output logic pick_loc,
  output logic pick_lft
);
  generate
    if (LOCAL_FIRST) begin : g_local_first
      assign pick_loc = en & loc_req;
      assign pick_lft = en & lft_req & ~loc_req;
    end else begin : g_left_first
      assign pick_lft = en & lft_req;
      assign pick_loc = en & loc_req & ~lft_req;
    end
  endgenerate
endmodule

// File: rtl/lrn_ctrl.sv
module lrn_ctrl
  import lrn_pkg::*;
#(
  parameter bit HAS_TOKEN = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pick_loc,
  input  logic       pick_lft,
  input  logic       cli_req,
  input  logic       cli_done,
  input  logic       lft_req,
  input  logic       rgt_ack,
  output lrn_state_e state,
  output logic       tok
);
  lrn_owner_e owner;
  logic       done_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      owner     <= SRV_LOCAL;
      done_seen <= 1'b0;
      tok       <= HAS_TOKEN;
    end else begin
      case (state)
        ST_IDLE: begin
          done_seen <= 1'b0;
          if (pick_loc) begin
            owner <= SRV_LOCAL;
            state <= tok ? ST_GRANTED : ST_FETCH;
          end else if (pick_lft) begin
            owner <= SRV_LEFT;
            if (tok) begin
              tok   <= 1'b0;
              state <= ST_PASS;
            end else begin
              state <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (rgt_ack) begin
            tok   <= 1'b1;
            state <= ST_RETURN;
          end
        end
        ST_RETURN: begin
          if (!rgt_ack) begin
            if (owner == SRV_LOCAL) begin
              state <= ST_GRANTED;
            end else begin
              tok   <= 1'b0;
              state <= ST_PASS;
            end
          end
        end
        ST_GRANTED: begin
          if (cli_done) done_seen <= 1'b1;
          if ((done_seen || cli_done) && !cli_req) state <= ST_IDLE;
        end
        ST_PASS: begin
          if (!lft_req) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lazy_ring_node.sv
module lazy_ring_node
  import lrn_pkg::*;
#(
  parameter bit HAS_TOKEN = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cli_req,
  input  logic cli_done,
  output logic cli_grant,
  input  logic lft_req,
  output logic lft_ack,
  output logic rgt_req,
  input  logic rgt_ack,
  output logic holds_token
);
  lrn_state_e state;
  logic       tok;
  logic       pick_loc;
  logic       pick_lft;

  lrn_mutex #(.LOCAL_FIRST(1'b1)) u_mutex (
    .en       (state == ST_IDLE),
    .loc_req  (cli_req),
    .lft_req  (lft_req),
    .pick_loc (pick_loc),
    .pick_lft (pick_lft)
  );

  lrn_ctrl #(.HAS_TOKEN(HAS_TOKEN)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .pick_loc (pick_loc),
    .pick_lft (pick_lft),
    .cli_req  (cli_req),
    .cli_done (cli_done),
    .lft_req  (lft_req),
    .rgt_ack  (rgt_ack),
    .state    (state),
    .tok      (tok)
  );

  assign cli_grant   = (state == ST_GRANTED);
  assign lft_ack     = (state == ST_PASS);
  assign rgt_req     = (state == ST_FETCH);
  assign holds_token = tok;
endmodule

// File: rtl/lrn_checker.sv
module lrn_checker (
  input logic clk,
  input logic rst_n,
  input logic cli_req,
  input logic cli_grant,
  input logic lft_req,
  input logic lft_ack,
  input logic rgt_req,
  input logic rgt_ack,
  input logic holds_token
);
  // R2
  grant_has_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cli_grant |-> holds_token);
  // R4
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cli_grant && cli_req) |=> cli_grant);
  // R5
  lack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lft_ack && lft_req) |=> lft_ack);
  // R5
  lack_token_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lft_ack) |-> !holds_token);
  // R8
  rreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rgt_req && !rgt_ack) |=> rgt_req);
  // R8
  rreq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rgt_req) |-> $past(rgt_ack));
  // R10
  one_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cli_grant, lft_ack, rgt_req}));
endmodule

bind lazy_ring_node lrn_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cli_req     (cli_req),
  .cli_grant   (cli_grant),
  .lft_req     (lft_req),
  .lft_ack     (lft_ack),
  .rgt_req     (rgt_req),
  .rgt_ack     (rgt_ack),
  .holds_token (holds_token)
);

// File: tb/lazy_ring_node_tb.sv
module lazy_ring_node_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NODES = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [NODES-1:0] req = '0;
  logic [NODES-1:0] done = '0;
  wire  [NODES-1:0] grant, lreq, lack, rreq, rack, tokv;

  for (genvar i = 0; i < NODES; i++) begin : g_node
    lazy_ring_node #(.HAS_TOKEN(i == 0)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cli_req(req[i]), .cli_done(done[i]), .cli_grant(grant[i]),
      .lft_req(lreq[i]), .lft_ack(lack[i]),
      .rgt_req(rreq[i]), .rgt_ack(rack[i]),
      .holds_token(tokv[i])
    );
    assign lreq[(i + 1) % NODES] = rreq[i];
    assign rack[i] = lack[(i + 1) % NODES];
  end

  int checks = 0;
  int fails = 0;
  int ring_bad = 0;
  int exp_q[$];
  logic [NODES-1:0] gprev = '0;
  logic [NODES-1:0] rseen = '0;
  logic [NODES-1:0] aseen = '0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // scoreboard monitor: grant order and fetch rules
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NODES; i++) begin
        if (rreq[i]) rseen[i] = 1'b1;
        if (rack[i]) aseen[i] = 1'b1;
        if (grant[i] && !gprev[i]) begin
          if (exp_q.size() == 0) chk(1'b0, "R7", "unexpected grant node", i, -1);
          else begin
            int e;
            e = exp_q.pop_front();
            chk(e == i, "R7", "grant order node", i, e);
          end
          if (rseen[i]) chk(aseen[i] && !rreq[i], "R3", "grant before fetch done", int'(aseen[i]), 1);
        end
      end
      if ($countones(tokv) > 1 || $countones(grant) > 1) ring_bad++;
      gprev = grant;
    end
  end

  task automatic wait_grant(input int n);
    for (int k = 0; k < 300; k++) begin
      if (grant[n]) break;
      @(negedge clk);
    end
  endtask

  task automatic finish_txn(input int n, input string rq);
    repeat (2) @(negedge clk);
    done[n] = 1'b1;
    @(negedge clk);
    done[n] = 1'b0;
    chk(grant[n] == 1'b1, "R4", "grant held while request high", int'(grant[n]), 1);
    req[n] = 1'b0;
    @(negedge clk);
    chk(grant[n] == 1'b0, rq, "grant dropped after request low", int'(grant[n]), 0);
    @(negedge clk);
  endtask

  task automatic client(input int n);
    exp_q.push_back(n);
    rseen[n] = 1'b0;
    aseen[n] = 1'b0;
    req[n] = 1'b1;
    @(negedge clk);
    wait_grant(n);
    chk(grant[n] == 1'b1, "R3", "grant eventually given", int'(grant[n]), 1);
    finish_txn(n, "R4");
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1 during reset
    chk(tokv == 3'b001, "R1", "token map in reset", int'(tokv), 1);
    chk(grant == 0 && lack == 0 && rreq == 0, "R1", "outputs in reset", int'(grant | lack | rreq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tokv == 3'b001, "R1", "token map after reset", int'(tokv), 1);

    // R2: holder is granted after one edge, no ring traffic
    exp_q.push_back(0);
    rseen[0] = 1'b0;
    req[0] = 1'b1;
    @(negedge clk);
    chk(grant[0] == 1'b1, "R2", "grant one edge after request", int'(grant[0]), 1);
    chk(rseen[0] == 1'b0, "R2", "no right request", int'(rseen[0]), 0);
    finish_txn(0, "R4");
    chk(tokv == 3'b001, "R4", "token kept after use", int'(tokv), 1);

    // R4: repeat request still needs no ring traffic
    exp_q.push_back(0);
    rseen[0] = 1'b0;
    req[0] = 1'b1;
    @(negedge clk);
    chk(grant[0] == 1'b1 && rseen[0] == 1'b0, "R4", "repeat grant without fetch", int'(grant[0]), 1);
    finish_txn(0, "R4");

    // R3 and R5: node 2 fetches from node 0
    rseen[2] = 1'b0;
    exp_q.push_back(2);
    aseen[2] = 1'b0;
    req[2] = 1'b1;
    @(negedge clk);
    chk(rreq[2] == 1'b1 && grant[2] == 1'b0, "R3", "right request raised first", int'(rreq[2]), 1);
    wait_grant(2);
    chk(grant[2] == 1'b1 && rreq[2] == 1'b0, "R8", "fetch returned to zero before grant", int'(rreq[2]), 0);
    finish_txn(2, "R4");
    chk(tokv == 3'b100, "R5", "token moved from node 0 to node 2", int'(tokv), 4);

    // R6: node 1 lacks the token, fetches for node 0 and forwards it
    rseen[1] = 1'b0;
    client(0);
    chk(rseen[1] == 1'b1, "R6", "intermediate node fetched", int'(rseen[1]), 1);
    chk(tokv == 3'b001, "R6", "intermediate node did not keep token", int'(tokv), 1);

    // R7: local and left requests reach node 0 in the same cycle
    exp_q.push_back(0);
    exp_q.push_back(2);
    rseen[2] = 1'b0;
    aseen[2] = 1'b0;
    rseen[0] = 1'b0;
    req[2] = 1'b1;
    @(negedge clk);
    req[0] = 1'b1;
    @(negedge clk);
    chk(grant[0] == 1'b1, "R7", "local wins tie", int'(grant[0]), 1);
    chk(lack[0] == 1'b0, "R7", "left waits during grant", int'(lack[0]), 0);
    finish_txn(0, "R7");
    wait_grant(2);
    chk(grant[2] == 1'b1, "R7", "left served after local", int'(grant[2]), 1);
    finish_txn(2, "R4");

    // R9: ring-wide exclusivity
    chk(ring_bad == 0, "R9", "cycles with two holders or two grants", ring_bad, 0);
    chk($countones(tokv) == 1, "R9", "exactly one token at end", $countones(tokv), 1);
    chk(exp_q.size() == 0, "R7", "pending expected grants", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 50000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule